// File: doc/BRIEF.md
# Load/Store Size, Extension and Alignment Unit

This block sits between a 64-bit register datapath and a little-endian data memory port that is one quadword wide. A store request carries an effective address, an access size and the register value. The block turns it into a quadword-aligned memory address, a write word with the data moved into the addressed byte lanes, and a byte-enable mask. A load request issues an aligned read and records where the wanted bytes sit. When the memory returns the quadword, the block picks out those bytes and widens them to 64 bits. Longword results are sign-extended. Byte and word results are zero-extended.

Every request is checked for natural alignment before it reaches memory. A misaligned word, longword or quadword access does not go to memory. Instead the block reports a fault with the original address and a flag that is 1 for a write and 0 for a read. A separate unaligned-quadword request flag applies only to quadword accesses. With it set, the low three address bits are dropped and the whole containing quadword is moved, and no fault is ever raised. Request outputs are registered and appear one cycle after the request. A load result appears one cycle after the memory return.

Top module: `lsu_align_unit`

## Requirements
- R1: During and after reset, `mem_wen`, `mem_ren`, `ld_valid` and `flt_valid` are 0 and `mem_be` is all zero.
- R2: An aligned byte, word or longword store sets `mem_wen` in the next cycle. The sizes are encoded as 00 byte, 01 word and 10 longword. Byte lane k of the write word holds bits 8k+7:8k. The data byte at index i is placed in lane `req_addr[2:0]`+i, and only those lanes are set in `mem_be`. All other lanes of `mem_wdata` are zero.
- R3: An aligned quadword store (size 11) gives `mem_be` = 8'hFF and `mem_wdata` equal to `req_wdata`.
- R4: For every issued access, `mem_addr` equals `req_addr` with bits 2:0 cleared.
- R5: A byte or word load returns the addressed bytes of `mem_rdata`, starting at lane `req_addr[2:0]`, zero-extended to 64 bits.
- R6: A longword load returns the addressed 32 bits, sign-extended from bit 31.
- R7: A quadword load returns `mem_rdata` unchanged.
- R8: A word access with address bit 0 set, a longword access with bits 1:0 nonzero, or a quadword access with bits 2:0 nonzero (without the unaligned flag) sets `flt_valid` in the next cycle. In that cycle `flt_addr` equals `req_addr`, `flt_write` equals `req_store`, and `mem_wen`, `mem_ren` and `mem_be` are all 0.
- R9: A quadword access with `req_unaligned` set never faults. It issues with address bits 2:0 cleared and `mem_be` = 8'hFF, and the whole quadword is moved. For smaller sizes `req_unaligned` has no effect.
- R10: `ld_valid` pulses exactly one cycle after a `mem_rvalid` that answers an issued load. A `mem_rvalid` with no load outstanding, including one after a faulted load, produces no `ld_valid`.
- R11: Byte accesses never fault, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 word, 10 longword, 11 quadword |
| req_unaligned | input | 1 | Unaligned-quadword form (quadword only) |
| req_addr | input | 64 | Effective byte address |
| req_wdata | input | 64 | Store source register value |
| mem_addr | output | 64 | Quadword-aligned memory address |
| mem_wen | output | 1 | Memory write strobe |
| mem_ren | output | 1 | Memory read strobe |
| mem_be | output | 8 | Byte lane enables |
| mem_wdata | output | 64 | Lane-aligned write word |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 64 | Returned quadword |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 64 | Extended load result |
| flt_valid | output | 1 | Alignment fault pulse |
| flt_addr | output | 64 | Faulting address |
| flt_write | output | 1 | 1 = faulting write, 0 = faulting read |

## Verification
Several properties are checked by assertions on every cycle:
- a fault never comes with a memory strobe or byte enables;
- the fault, write and read strobes are mutually exclusive;
- issued addresses are always quadword-aligned and the byte-enable count is always a power of two;
- misaligned words and longwords always fault, while byte and unaligned-quadword requests never fault;
- a load result only follows a memory return.

Other behaviours can only be shown by the bench's scenarios, where expected values are computed independently:
- the exact lane placement of store data;
- the sign and zero extension of load results;
- the value of the fault address;
- the dropping of stray returns after a faulted load.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        SZ_B8  = 2'b00,
        SZ_B16 = 2'b01,
        SZ_B32 = 2'b10,
        SZ_B64 = 2'b11
    } acc_size_e;

endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check #(
    parameter int OFF_W = 3
) (
    input  lsu_pkg::acc_size_e  size,
    input  logic [OFF_W-1:0]    low_addr,
    input  logic                unaligned_q,
    output logic                misaligned,
    output logic [OFF_W-1:0]    eff_off
);
    import lsu_pkg::*;

    logic               widest_free;
    logic [OFF_W-1:0]   need_zero;

    always_comb begin
        // the unaligned form is honoured only at full quadword size
        widest_free = (size == SZ_B64) && unaligned_q;
        // mask of address bits that must be zero for natural alignment
        need_zero   = OFF_W'((1 << size) - 1);
        misaligned  = !widest_free && (|(low_addr & need_zero));
        eff_off     = widest_free ? '0 : low_addr;
    end

endmodule

// File: rtl/lsu_store_align.sv
module lsu_store_align #(
    parameter int DATA_W = 64,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  lsu_pkg::acc_size_e  size,
    input  logic [OFF_W-1:0]    off,
    input  logic [DATA_W-1:0]   src,
    output logic [LANES-1:0]    lane_be,
    output logic [DATA_W-1:0]   lane_data
);
    logic [OFF_W+1:0]   nbytes;
    logic [OFF_W+1:0]   lane_end;
    logic [DATA_W-1:0]  trimmed;

    always_comb begin
        nbytes   = (OFF_W+2)'(1) << size;
        lane_end = (OFF_W+2)'(off) + nbytes;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W+1:0] IDX = (OFF_W+2)'(i);
        // keep only the source bytes that the access size covers
        assign trimmed[8*i +: 8] = (IDX < nbytes) ? src[8*i +: 8] : 8'h00;
        // a lane is written when it falls inside [off, off+nbytes)
        assign lane_be[i] = (IDX >= (OFF_W+2)'(off)) && (IDX < lane_end);
    end

    assign lane_data = trimmed << {off, 3'b000};

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
    parameter int DATA_W = 64,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  lsu_pkg::acc_size_e  size,
    input  logic [OFF_W-1:0]    off,
    input  logic [DATA_W-1:0]   raw,
    output logic [DATA_W-1:0]   result
);
    import lsu_pkg::*;

    logic [OFF_W+1:0]   nbytes;
    logic [DATA_W-1:0]  moved;
    logic               sign_bit;
    logic [7:0]         fill;

    always_comb begin
        nbytes   = (OFF_W+2)'(1) << size;
        moved    = raw >> {off, 3'b000};
        // only longword loads widen with the sign; byte and word fill zeros
        sign_bit = moved[31];
        fill     = (size == SZ_B32 && sign_bit) ? 8'hFF : 8'h00;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W+1:0] IDX = (OFF_W+2)'(i);
        assign result[8*i +: 8] = (IDX < nbytes) ? moved[8*i +: 8] : fill;
    end

endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_store,
    input  logic [1:0]          req_size,
    input  logic                req_unaligned,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_wen,
    output logic                mem_ren,
    output logic [LANES-1:0]    mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_rvalid,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                ld_valid,
    output logic [DATA_W-1:0]   ld_data,
    output logic                flt_valid,
    output logic [ADDR_W-1:0]   flt_addr,
    output logic                flt_write
);
    import lsu_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0]  mem_addr;
        logic               wen;
        logic               ren;
        logic [LANES-1:0]   be;
        logic [DATA_W-1:0]  wdata;
        logic               ld_pend;
        acc_size_e          ld_size;
        logic [OFF_W-1:0]   ld_off;
        logic               ld_valid;
        logic [DATA_W-1:0]  ld_data;
        logic               flt_valid;
        logic [ADDR_W-1:0]  flt_addr;
        logic               flt_write;
    } lsu_state_t;

    lsu_state_t st_d, st_q;

    acc_size_e          size_in;
    logic               mis;
    logic [OFF_W-1:0]   off;
    logic [LANES-1:0]   lane_be;
    logic [DATA_W-1:0]  lane_data;
    logic [DATA_W-1:0]  ext_result;

    assign size_in = acc_size_e'(req_size);

    lsu_align_check #(.OFF_W(OFF_W)) u_check (
        .size        (size_in),
        .low_addr    (req_addr[OFF_W-1:0]),
        .unaligned_q (req_unaligned),
        .misaligned  (mis),
        .eff_off     (off)
    );

    lsu_store_align #(.DATA_W(DATA_W)) u_store (
        .size      (size_in),
        .off       (off),
        .src       (req_wdata),
        .lane_be   (lane_be),
        .lane_data (lane_data)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) u_load (
        .size   (st_q.ld_size),
        .off    (st_q.ld_off),
        .raw    (mem_rdata),
        .result (ext_result)
    );

    always_comb begin
        st_d           = st_q;
        st_d.wen       = 1'b0;
        st_d.ren       = 1'b0;
        st_d.be        = '0;
        st_d.ld_valid  = 1'b0;
        st_d.flt_valid = 1'b0;

        // memory return: accepted only while a load is outstanding
        if (mem_rvalid && st_q.ld_pend) begin
            st_d.ld_valid = 1'b1;
            st_d.ld_data  = ext_result;
            st_d.ld_pend  = 1'b0;
        end

        if (req_valid) begin
            if (mis) begin
                st_d.flt_valid = 1'b1;
                st_d.flt_addr  = req_addr;
                st_d.flt_write = req_store;
            end else begin
                st_d.mem_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                st_d.be       = lane_be;
                if (req_store) begin
                    st_d.wen   = 1'b1;
                    st_d.wdata = lane_data;
                end else begin
                    st_d.ren     = 1'b1;
                    st_d.ld_pend = 1'b1;
                    st_d.ld_size = size_in;
                    st_d.ld_off  = off;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = st_q.mem_addr;
    assign mem_wen   = st_q.wen;
    assign mem_ren   = st_q.ren;
    assign mem_be    = st_q.be;
    assign mem_wdata = st_q.wdata;
    assign ld_valid  = st_q.ld_valid;
    assign ld_data   = st_q.ld_data;
    assign flt_valid = st_q.flt_valid;
    assign flt_addr  = st_q.flt_addr;
    assign flt_write = st_q.flt_write;

endmodule

// File: rtl/lsu_align_checker.sv
module lsu_align_checker #(
    parameter int ADDR_W = 64,
    parameter int LANES  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_store,
    input logic [1:0]        req_size,
    input logic              req_unaligned,
    input logic [ADDR_W-1:0] req_addr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_wen,
    input logic              mem_ren,
    input logic [LANES-1:0]  mem_be,
    input logic              mem_rvalid,
    input logic              ld_valid,
    input logic              flt_valid,
    input logic              flt_write
);

    a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> (!mem_wen && !mem_ren && mem_be == '0));

    a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wen, mem_ren, flt_valid}));

    a_r8_word_odd_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b01 && req_addr[0]) |=> (flt_valid && flt_write == $past(req_store)));

    a_r8_long_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b10 && req_addr[1:0] != 2'b00) |=> flt_valid);

    a_r4_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen || mem_ren) |-> (mem_addr[2:0] == 3'b000));

    a_r2_be_span: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen || mem_ren) |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                                  $countones(mem_be) == 4 || $countones(mem_be) == 8));

    a_r9_unaligned_quad: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b11 && req_unaligned) |=> (!flt_valid && mem_be == '1));

    a_r11_byte_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b00) |=> !flt_valid);

    a_r10_ld_after_return: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_rvalid));

endmodule

bind lsu_align_unit lsu_align_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_store     (req_store),
    .req_size      (req_size),
    .req_unaligned (req_unaligned),
    .req_addr      (req_addr),
    .mem_addr      (mem_addr),
    .mem_wen       (mem_wen),
    .mem_ren       (mem_ren),
    .mem_be        (mem_be),
    .mem_rvalid    (mem_rvalid),
    .ld_valid      (ld_valid),
    .flt_valid     (flt_valid),
    .flt_write     (flt_write)
);

// File: tb/lsu_align_unit_bench.sv
module lsu_align_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_unaligned = 1'b0;
    logic [63:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] mem_addr;
    logic        mem_wen, mem_ren;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        ld_valid;
    logic [63:0] ld_data;
    logic        flt_valid;
    logic [63:0] flt_addr;
    logic        flt_write;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_align_unit u_lsu_align_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_unaligned(req_unaligned), .req_addr(req_addr),
        .req_wdata(req_wdata), .mem_addr(mem_addr), .mem_wen(mem_wen),
        .mem_ren(mem_ren), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
        .ld_data(ld_data), .flt_valid(flt_valid), .flt_addr(flt_addr),
        .flt_write(flt_write)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit exp_fault(logic [1:0] sz, logic [63:0] a, bit uq);
        if (sz == 2'b11 && uq) return 1'b0;
        return (a[2:0] & 3'((1 << sz) - 1)) != 3'b000;
    endfunction

    function automatic int exp_off(logic [1:0] sz, logic [63:0] a, bit uq);
        if (sz == 2'b11 && uq) return 0;
        return int'(a[2:0]);
    endfunction

    function automatic logic [7:0] exp_be(logic [1:0] sz, int off);
        logic [7:0] m = '0;
        for (int i = 0; i < (1 << sz); i++) m[off + i] = 1'b1;
        return m;
    endfunction

    function automatic logic [63:0] exp_wd(logic [1:0] sz, int off, logic [63:0] d);
        logic [63:0] w = '0;
        for (int i = 0; i < (1 << sz); i++) w[8*(off+i) +: 8] = d[8*i +: 8];
        return w;
    endfunction

    function automatic logic [63:0] exp_ld(logic [1:0] sz, int off, logic [63:0] r);
        logic [63:0] v = '0;
        for (int i = 0; i < (1 << sz); i++) v[8*i +: 8] = r[8*(off+i) +: 8];
        if (sz == 2'b10 && v[31]) v[63:32] = '1;
        return v;
    endfunction

    // issue one access; for a non-faulting load, return rdata one cycle later
    task automatic access(input bit st, input logic [1:0] sz, input logic [63:0] a,
                          input logic [63:0] d, input bit uq, input logic [63:0] rd);
        bit f;
        int off;
        f   = exp_fault(sz, a, uq);
        off = exp_off(sz, a, uq);
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_size = sz; req_addr = a;
        req_wdata = d; req_unaligned = uq;
        @(negedge clk);
        req_valid = 1'b0;
        if (f) begin
            check(flt_valid === 1'b1, "R8 fault raised", 64'(flt_valid), 64'd1);
            check(flt_addr === a, "R8 fault address", flt_addr, a);
            check(flt_write === st, "R8 fault write flag", 64'(flt_write), 64'(st));
            check(!mem_wen && !mem_ren && mem_be == 8'h00, "R8 no access on fault",
                  {mem_wen, mem_ren, mem_be}, 64'd0);
        end else begin
            check(flt_valid === 1'b0, "R8/R9/R11 no fault", 64'(flt_valid), 64'd0);
            check(mem_addr === {a[63:3], 3'b000}, "R4 aligned address", mem_addr, {a[63:3], 3'b000});
            check(mem_be === exp_be(sz, off), "R2/R9 byte enables", 64'(mem_be), 64'(exp_be(sz, off)));
            if (st) begin
                check(mem_wen === 1'b1 && mem_ren === 1'b0, "R2 write strobe", 64'(mem_wen), 64'd1);
                check(mem_wdata === exp_wd(sz, off, d), "R2/R3 write data", mem_wdata, exp_wd(sz, off, d));
            end else begin
                check(mem_ren === 1'b1 && mem_wen === 1'b0, "R5 read strobe", 64'(mem_ren), 64'd1);
                mem_rvalid = 1'b1; mem_rdata = rd;
                @(negedge clk);
                mem_rvalid = 1'b0;
                check(ld_valid === 1'b1, "R10 load valid", 64'(ld_valid), 64'd1);
                check(ld_data === exp_ld(sz, off, rd), "R5/R6/R7 load data", ld_data, exp_ld(sz, off, rd));
            end
        end
    endtask

    // a stray memory return must not produce a load result
    task automatic stray_return(input logic [63:0] rd);
        @(negedge clk);
        mem_rvalid = 1'b1; mem_rdata = rd;
        @(negedge clk);
        mem_rvalid = 1'b0;
        check(ld_valid === 1'b0, "R10 stray return ignored", 64'(ld_valid), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!mem_wen && !mem_ren && !ld_valid && !flt_valid && mem_be == 8'h00,
              "R1 reset outputs", {mem_wen, mem_ren, ld_valid, flt_valid, mem_be}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_wen && !mem_ren && !ld_valid && !flt_valid, "R1 idle after reset",
              {mem_wen, mem_ren, ld_valid, flt_valid}, 64'd0);

        // directed stores: R2 lane placement, R3 full quadword
        access(1, 2'b00, 64'h1000_0007, 64'h1122_3344_5566_77AB, 0, '0);
        access(1, 2'b01, 64'h1000_0006, 64'hFFFF_FFFF_FFFF_BEEF, 0, '0);
        access(1, 2'b10, 64'h1000_0004, 64'hAAAA_AAAA_DEAD_C0DE, 0, '0);
        access(1, 2'b11, 64'h2000_0008, 64'h0123_4567_89AB_CDEF, 0, '0);
        // directed loads: R5 zero extension, R6 sign extension, R7 quadword
        access(0, 2'b00, 64'h3000_0003, '0, 0, 64'h0000_0000_8000_0000);
        access(0, 2'b01, 64'h3000_0002, '0, 0, 64'h0000_0000_8001_0000);
        access(0, 2'b10, 64'h3000_0004, '0, 0, 64'h8000_0001_0000_0000);
        access(0, 2'b10, 64'h3000_0000, '0, 0, 64'hFFFF_FFFF_7FFF_FFFF);
        access(0, 2'b11, 64'h3000_0010, '0, 0, 64'hFEDC_BA98_7654_3210);
        // R8 faults, both directions
        access(1, 2'b01, 64'h4000_0001, 64'h1, 0, '0);
        access(0, 2'b10, 64'h4000_0002, '0, 0, '0);
        stray_return(64'hFFFF_FFFF_FFFF_FFFF);  // R10 after faulted load
        access(1, 2'b11, 64'h4000_0004, 64'h5, 0, '0);
        // R9 unaligned quadword form; ignored for smaller sizes
        access(0, 2'b11, 64'h5000_0005, '0, 1, 64'h8899_AABB_CCDD_EEFF);
        access(1, 2'b11, 64'h5000_000F, 64'hCAFE_F00D_1234_5678, 1, '0);
        access(1, 2'b01, 64'h5000_0003, 64'h9, 1, '0);
        // R11 byte never faults
        access(0, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, '0, 0, 64'hA5A5_A5A5_A5A5_A5A5);
        stray_return(64'h1234);  // R10 no load outstanding

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [63:0] a, d, r;
            logic [1:0]  sz;
            bit st, uq;
            a  = {$urandom, $urandom};
            d  = {$urandom, $urandom};
            r  = {$urandom, $urandom};
            sz = 2'($urandom_range(0, 3));
            st = 1'($urandom_range(0, 1));
            uq = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 1) == 1) a[2:0] = a[2:0] & 3'(~((1 << sz) - 1));
            access(st, sz, a, d, uq, r);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule